// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

This block sits between an eight-pin digital port and a fixed group of peripheral signals. Every pin owns a small code register. The stored code selects which peripheral output drives the pin. The same code also selects which peripheral input the pin's sampled level feeds. Software writes and reads the codes through a simple register port. Each pin then gets its output value, output enable and input-buffer enable from the code.

Some codes belong to serial interfaces. For those codes the owning peripheral sets the pin direction, and the port's own direction bit has no say. Two of these codes switch to open-drain behaviour when the serial peripheral runs its two-wire bus mode. A dedicated analog code turns off both pad buffers. Several pins may select the same input function. In that case the peripheral sees the OR of their levels, so the routing cannot create a conflict.

Top module: `pinfx_xbar`

## Requirements
- R1: A write to a pin's code register stores only the low 5 bits of the write data and takes effect at the clock edge on which the write enable is sampled high. Writing 0xFF reads back 31, and writing 0x35 reads back 21. A read returns the stored code of the addressed pin, zero-extended to 8 bits, and the code holds when no write occurs.
- R2: After reset, pins 0 to 5 hold codes 16, 15, 14, 13, 12 and 11 in that order, and pins 6 and 7 hold code 0.
- R3: Code 31 (analog) forces the pin's output value, output enable and input enable to 0. The pin's level then reaches no peripheral input.
- R4: Code 0 and codes 19 to 30 drive the pin output to 0, leave output enable equal to the pin's direction bit, and route the pin to no peripheral input.
- R5: For codes 1 to 18 the pin output equals bit `code` of `per_out`, except in the open-drain case of R8.
- R6: For codes 1 to 10, 17 and 18, the pin's output enable equals its bit of `pin_dir`.
- R7: For the serial codes 11 to 16, the pin's output enable equals bit `code` of `per_dir`, independent of `pin_dir`, except in the open-drain case of R8.
- R8: When `i2c_mode` is 1 and a pin holds code 14 or 15, the pin output is 0 and its output enable is bit `code` of `per_dir` AND the inverse of bit `code` of `per_out`. The pin therefore pulls low only.
- R9: For f in 1 to 16, `per_in[f]` is the OR of `pin_in` over all pins holding code f, and 0 when no pin holds f. Bits 0, 17 and 18 of `per_in` are always 0.
- R10: `pin_ie` is 1 for every pin whose code is not 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed code register |
| addr | input | 3 | Pin index for read and write |
| wdata | input | 8 | Write data (low 5 bits kept) |
| rdata | output | 8 | Code of the addressed pin, zero-extended |
| pin_dir | input | 8 | Per-pin direction bits (1 = drive) |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_ie | output | 8 | Per-pin input-buffer enable |
| per_out | input | 19 | Peripheral output signals, bit index = code |
| per_dir | input | 19 | Peripheral direction requests, bit index = code |
| i2c_mode | input | 1 | Serial peripheral in two-wire bus mode |
| per_in | output | 19 | Peripheral input signals, bit index = code |

## Verification
On every cycle, the embedded assertions check four things. An analog pin is fully quiet. An open-drain pin never drives high. Direction comes from the right source for serial and non-serial codes. A code register changes only through a write, and after a write it holds the truncated value. A further check confirms that a port with no routed levels presents all-zero peripheral inputs. Only the bench scenarios show the rest: the reset code pattern, the OR merge when two pins share a function, the reserved codes, and the full output mapping under random codes and random peripheral activity.

// File: rtl/pinfx_pkg.sv
package pinfx_pkg;
  localparam int CODE_W  = 5;
  localparam int NFUNC   = 19;
  localparam int ANALOG  = 31;
  localparam int SER_LO  = 11;
  localparam int SER_HI  = 16;
  localparam int OD_CLK  = 14;
  localparam int OD_DAT  = 15;
  localparam int IN_HI   = 16;
  localparam int OUT_HI  = 18;
  localparam int NDEFLT  = 6;

  function automatic logic fx_has_output(input logic [CODE_W-1:0] c);
    return (int'(c) >= 1) && (int'(c) <= OUT_HI);
  endfunction

  function automatic logic fx_has_input(input logic [CODE_W-1:0] c);
    return (int'(c) >= 1) && (int'(c) <= IN_HI);
  endfunction

  function automatic logic fx_is_serial(input logic [CODE_W-1:0] c);
    return (int'(c) >= SER_LO) && (int'(c) <= SER_HI);
  endfunction

  function automatic logic fx_is_od(input logic [CODE_W-1:0] c);
    return (int'(c) == OD_CLK) || (int'(c) == OD_DAT);
  endfunction

  function automatic logic [CODE_W-1:0] fx_reset_code(input int idx);
    return (idx < NDEFLT) ? CODE_W'(SER_HI - idx) : '0;
  endfunction
endpackage

// File: rtl/pinfx_map_regs.sv
module pinfx_map_regs
  import pinfx_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(NPINS)
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NPINS-1:0][CODE_W-1:0]  map_q
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) map_q[i] <= fx_reset_code(i);
    end else if (wr_en) begin
      map_q[addr] <= wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CODE_W-1:0] = map_q[addr];
  end

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(addr)] == $past(wdata[CODE_W-1:0]));
  assert_code_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(map_q));
endmodule

// File: rtl/pinfx_pin_slice.sv
module pinfx_pin_slice
  import pinfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              pin_dir,
  input  logic              pin_in,
  input  logic [NFUNC-1:0]  per_out,
  input  logic [NFUNC-1:0]  per_dir,
  input  logic              i2c_mode,
  output logic              out,
  output logic              oe,
  output logic              ie,
  output logic [NFUNC-1:0]  route
);
  logic is_analog, is_serial, od_act, src_bit, dir_bit;

  assign is_analog = (int'(code) == ANALOG);
  assign is_serial = fx_is_serial(code);
  assign od_act    = i2c_mode && fx_is_od(code);
  assign src_bit   = fx_has_output(code) ? per_out[code] : 1'b0;
  assign dir_bit   = is_serial ? per_dir[code] : 1'b0;

  always_comb begin
    out = od_act ? 1'b0 : src_bit;
    if (is_analog)      oe = 1'b0;
    else if (od_act)    oe = dir_bit & ~src_bit;
    else if (is_serial) oe = dir_bit;
    else                oe = pin_dir;
    ie = !is_analog;
    for (int f = 0; f < NFUNC; f++)
      route[f] = fx_has_input(code) && (int'(code) == f) && pin_in;
  end

  assert_analog_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_analog |-> (!oe && !ie && !out && route == '0));
  assert_od_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    od_act |-> (!out && (!oe || !per_out[code])));
  assert_plain_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_serial && !is_analog) |-> oe == pin_dir);
  assert_serial_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_serial && !od_act) |-> oe == per_dir[code]);
endmodule

// File: rtl/pinfx_in_merge.sv
module pinfx_in_merge
  import pinfx_pkg::*;
#(
  parameter int NPINS = 8
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPINS-1:0][NFUNC-1:0] route,
  output logic [NFUNC-1:0]            per_in
);
  for (genvar f = 0; f < NFUNC; f++) begin : g_func
    logic [NPINS-1:0] col;
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign col[p] = route[p][f];
    end
    assign per_in[f] = |col;
  end

  assert_idle_inputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (route == '0) |-> per_in == '0);
endmodule

// File: rtl/pinfx_xbar.sv
module pinfx_xbar
  import pinfx_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(NPINS)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NPINS-1:0]   pin_dir,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_ie,
  input  logic [NFUNC-1:0]   per_out,
  input  logic [NFUNC-1:0]   per_dir,
  input  logic               i2c_mode,
  output logic [NFUNC-1:0]   per_in
);
  logic [NPINS-1:0][CODE_W-1:0] map_q;
  logic [NPINS-1:0][NFUNC-1:0]  route;

  pinfx_map_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .map_q(map_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pinfx_pin_slice u_slice (
      .clk(clk), .rst_n(rst_n), .code(map_q[p]),
      .pin_dir(pin_dir[p]), .pin_in(pin_in[p]),
      .per_out(per_out), .per_dir(per_dir), .i2c_mode(i2c_mode),
      .out(pin_out[p]), .oe(pin_oe[p]), .ie(pin_ie[p]), .route(route[p])
    );
  end

  pinfx_in_merge #(.NPINS(NPINS)) u_merge (
    .clk(clk), .rst_n(rst_n), .route(route), .per_in(per_in)
  );
endmodule

// File: tb/pinfx_xbar_tb.sv
module pinfx_xbar_tb;
  localparam int CLK_P = 10;
  localparam int NP = 8;
  localparam int NF = 19;

  logic clk = 0, rst_n = 0, wr_en = 0, i2c_mode = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NP-1:0] pin_dir = 0, pin_in = 0, pin_out, pin_oe, pin_ie;
  logic [NF-1:0] per_out = 0, per_dir = 0, per_in;
  logic [4:0] mdl [NP];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pinfx_xbar u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_dir(pin_dir), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_ie(pin_ie), .per_out(per_out), .per_dir(per_dir),
    .i2c_mode(i2c_mode), .per_in(per_in)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic e_out(input int p);
    case (mdl[p]) inside
      [5'd1:5'd13], 5'd16, 5'd17, 5'd18: return per_out[mdl[p]];
      5'd14, 5'd15: return i2c_mode ? 1'b0 : per_out[mdl[p]];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic e_oe(input int p);
    case (mdl[p]) inside
      5'd31: return 1'b0;
      5'd14, 5'd15: return i2c_mode ? (per_dir[mdl[p]] && !per_out[mdl[p]]) : per_dir[mdl[p]];
      [5'd11:5'd16]: return per_dir[mdl[p]];
      default: return pin_dir[p];
    endcase
  endfunction

  function automatic logic [NF-1:0] e_pin();
    logic [NF-1:0] v = '0;
    for (int p = 0; p < NP; p++)
      if (mdl[p] >= 1 && mdl[p] <= 16 && pin_in[p]) v[mdl[p]] = 1'b1;
    return v;
  endfunction

  task automatic check_all(input string ctx);
    logic [NP-1:0] eo, ee, ei;
    for (int p = 0; p < NP; p++) begin
      eo[p] = e_out(p); ee[p] = e_oe(p); ei[p] = (mdl[p] != 5'd31);
    end
    check("R5/R8/R4", {ctx, " pin_out"}, 32'(pin_out), 32'(eo));
    check("R6/R7/R3", {ctx, " pin_oe"}, 32'(pin_oe), 32'(ee));
    check("R10", {ctx, " pin_ie"}, 32'(pin_ie), 32'(ei));
    check("R9", {ctx, " per_in"}, 32'(per_in), 32'(e_pin()));
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr_en = 0;
    mdl[a] = d[4:0];
    #1;
  endtask

  task automatic rd_check(input string req, input int a, input logic [4:0] exp);
    addr = 3'(a);
    #1;
    check(req, $sformatf("rdata pin %0d", a), 32'(rdata), 32'(exp));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < NP; p++) mdl[p] = (p < 6) ? 5'(16 - p) : 5'd0;
    pin_dir = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset codes
    for (int p = 0; p < NP; p++) rd_check("R2", p, mdl[p]);
    per_out = '1; per_dir = '0; pin_in = 8'hFF;
    #1 check_all("reset R2 R10");

    // R1: truncation of upper bits
    wr(2, 8'hFF);
    rd_check("R1", 2, 5'd31);
    wr(3, 8'h35);
    rd_check("R1", 3, 5'd21);
    // R3: analog pin quiet even with direction set and level high
    check("R3", "oe pin2", 32'(pin_oe[2]), 0);
    check("R3", "ie pin2", 32'(pin_ie[2]), 0);
    check("R3", "per_in[14]", 32'(per_in[14]), 0);
    check_all("analog R3 / reserved R4");

    // R9: two pins share code 5, OR merge
    wr(6, 8'd5); wr(7, 8'd5);
    pin_in = 8'b0100_0000; #1;
    check("R9", "shared per_in[5]", 32'(per_in[5]), 1);
    pin_in = 8'b0000_0000; #1;
    check("R9", "shared per_in[5] low", 32'(per_in[5]), 0);
    per_out[5] = 1; pin_dir[7] = 0; #1;
    check("R5", "pin7 out", 32'(pin_out[7]), 1);
    check("R6", "pin7 oe", 32'(pin_oe[7]), 0);

    // R7: serial direction overrides pin_dir
    wr(4, 8'd12);
    pin_dir[4] = 0; per_dir[12] = 1; #1;
    check("R7", "serial oe", 32'(pin_oe[4]), 1);

    // R8: open drain on codes 14/15
    wr(0, 8'd14);
    i2c_mode = 1; per_dir[14] = 1; per_out[14] = 1; #1;
    check("R8", "od out high", 32'(pin_out[0]), 0);
    check("R8", "od oe released", 32'(pin_oe[0]), 0);
    per_out[14] = 0; #1;
    check("R8", "od oe pulls", 32'(pin_oe[0]), 1);
    check_all("directed R8");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] d;
      int a;
      a = $urandom_range(0, NP - 1);
      case ($urandom_range(0, 5))
        0: d = 8'hFF;
        1: d = 8'(31);
        2: d = 8'($urandom_range(19, 30));
        default: d = 8'($urandom);
      endcase
      wr(a, d);
      pin_dir = 8'($urandom); pin_in = 8'($urandom);
      per_out = NF'($urandom); per_dir = NF'($urandom);
      i2c_mode = 1'($urandom);
      #1;
      rd_check("R1", a, d[4:0]);
      check_all("random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule